// File: doc/BRIEF.md
# Dual-Enable Byte-Wide Static Memory Emulator

This block is a clocked stand-in for an asynchronous byte-wide static memory. A fast internal clock samples a 20-bit address, two chip selects (one active low, one active high), an active-low write strobe and an active-low read strobe. From these it derives one of four modes: deselected, outputs off, read and write. The bidirectional data bus is split into an input byte, an output byte and an output-drive enable. A pad ring or a bus model can merge them into a tri-state pin.

A write is not a single event. It is a window that stays open while both selects are active and the write strobe is low. The window closes when any one of those three goes inactive. The byte committed is the one sampled in the last cycle of the window, and it goes to the address captured when the window opened. If the address moves while the window is open, the block raises a protocol error and drops the write. A parameter shrinks the storage so the design can be simulated quickly. Only the low address bits then pick a location.

Top module: `bytewide_sram_emu`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `dout_en_o` and `proto_err_o` are 0.
- R2: If `sel_n_i` is 1 or `sel_i` is 0 when sampled, `dout_en_o` is 0 in the following cycle, whatever the other inputs are.
- R3: If the block is selected with `wr_n_i`=1 and `rd_n_i`=0, then one cycle later `dout_en_o` is 1 and `dout_o` holds the byte stored at the sampled address. `dout_o` is 0 whenever `dout_en_o` is 0.
- R4: If the block is selected with `wr_n_i`=1 and `rd_n_i`=1, `dout_en_o` is 0 in the following cycle.
- R5: If the block is selected with `wr_n_i`=0, the mode is write whatever `rd_n_i` is, and `dout_en_o` is 0 in the following cycle.
- R6: The write window is the run of sampled cycles in which both selects are active and `wr_n_i` is 0. Raising `wr_n_i`, raising `sel_n_i` or lowering `sel_i` each end it, and each commits the write exactly once.
- R7: The byte stored is the `din_i` sampled in the last cycle of the window. Values sampled earlier in the same window are discarded.
- R8: The address is captured when the window opens. If a later cycle of the same window samples a different address, the write is suppressed and the location keeps its old byte. `proto_err_o` goes to 1 one cycle after that cycle. It stays at 1 until the next window opens or reset is applied.
- R9: A read sampled in the cycle right after a window closes returns the new byte.
- R10: Only address bits [DEPTH_W-1:0] select a location (DEPTH_W defaults to 10), so addresses that differ only in the upper bits alias.
- R11: With the block deselected, a low `wr_n_i` changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Chip select, active low |
| sel_i | input | 1 | Chip select, active high |
| wr_n_i | input | 1 | Write strobe, active low |
| rd_n_i | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W (20) | Byte address |
| din_i | input | DATA_W (8) | Data bus, inbound half |
| dout_o | output | DATA_W (8) | Data bus, outbound half |
| dout_en_o | output | 1 | Drive enable for the outbound half |
| proto_err_o | output | 1 | Address moved inside an open write window |

## Verification
The assertions assume that every input is already synchronous to `clk` and known at each rising edge. They also assume that the drive enable depends only on the inputs sampled one edge earlier. The bench changes inputs only on the falling edge and holds them steady across each rising edge. It reads only locations it has already written, so the model's flags and compares never see an unknown value. Address changes inside a window appear only in the directed error case, where the bench provokes them on purpose.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE  = 2'd0,
      MODE_HIZ   = 2'd1,
      MODE_READ  = 2'd2,
      MODE_WRITE = 2'd3
   } mode_e;

   // Selection first, then the write strobe overrides the read strobe.
   function automatic mode_e decode_mode(input logic sel_n, input logic sel,
                                         input logic wr_n, input logic rd_n);
      if (sel_n || !sel)  return MODE_IDLE;
      else if (!wr_n)     return MODE_WRITE;
      else if (!rd_n)     return MODE_READ;
      else                return MODE_HIZ;
   endfunction

endpackage

// File: rtl/sram_emu_sampler.sv
module sram_emu_sampler #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n_i,
   input  logic              sel_i,
   input  logic              wr_n_i,
   input  logic              rd_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] din_i,
   output logic              sel_n_q,
   output logic              sel_q,
   output logic              wr_n_q,
   output logic              rd_n_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] din_q
);

   // Reset state reads as a deselected, idle bus.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_n_q <= 1'b1;
         sel_q   <= 1'b0;
         wr_n_q  <= 1'b1;
         rd_n_q  <= 1'b1;
         addr_q  <= '0;
         din_q   <= '0;
      end else begin
         sel_n_q <= sel_n_i;
         sel_q   <= sel_i;
         wr_n_q  <= wr_n_i;
         rd_n_q  <= rd_n_i;
         addr_q  <= addr_i;
         din_q   <= din_i;
      end
   end

endmodule

// File: rtl/sram_emu_write_ctrl.sv
module sram_emu_write_ctrl #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IDX_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [IDX_W-1:0]  hold_idx_o,
   output logic [DATA_W-1:0] hold_data_o,
   output logic              commit_o,
   output logic              err_o
);

   logic              win_q;
   logic              bad_q;
   logic [ADDR_W-1:0] hold_addr;
   logic [DATA_W-1:0] hold_data;
   logic              opening;
   logic              closing;

   assign opening = win_i && !win_q;
   assign closing = win_q && !win_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q     <= 1'b0;
         bad_q     <= 1'b0;
         hold_addr <= '0;
         hold_data <= '0;
      end else begin
         win_q <= win_i;
         if (opening) begin
            hold_addr <= addr_i;
            hold_data <= data_i;
            bad_q     <= 1'b0;
         end else if (win_i) begin
            hold_data <= data_i;
            if (addr_i != hold_addr) bad_q <= 1'b1;
         end
      end
   end

   assign hold_idx_o  = hold_addr[IDX_W-1:0];
   assign hold_data_o = hold_data;
   assign commit_o    = closing && !bad_q;
   assign err_o       = bad_q;

   AST_HOLD_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (win_i && win_q) |=> $stable(hold_addr));                             // R8
   AST_ERR_RISES_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bad_q) |-> $past(win_i && win_q));                              // R8
   AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> !commit_o);                                              // R6

endmodule

// File: rtl/sram_emu_array.sv
module sram_emu_array #(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned DEPTH_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [DEPTH_W-1:0] waddr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic [DEPTH_W-1:0] raddr_i,
   output logic [DATA_W-1:0]  rdata_o
);

   localparam int unsigned DEPTH = 1 << DEPTH_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) cells[waddr_i] <= wdata_i;
   end

   assign rdata_o = cells[raddr_i];

   AST_WRITE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |-> !$isunknown({waddr_i, wdata_i}));                            // R6

endmodule

// File: rtl/bytewide_sram_emu.sv
module bytewide_sram_emu
   import sram_emu_pkg::*;
#(
   parameter int unsigned ADDR_W  = 20,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned DEPTH_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n_i,
   input  logic              sel_i,
   input  logic              wr_n_i,
   input  logic              rd_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] dout_o,
   output logic              dout_en_o,
   output logic              proto_err_o
);

   if (DEPTH_W < 1 || DEPTH_W > ADDR_W) begin : g_bad_depth
      $error("DEPTH_W must lie between 1 and ADDR_W");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   logic              s_sel_n, s_sel, s_wr_n, s_rd_n;
   logic [ADDR_W-1:0] s_addr;
   logic [DATA_W-1:0] s_din;

   sram_emu_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sampler (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_n_i (sel_n_i),
      .sel_i   (sel_i),
      .wr_n_i  (wr_n_i),
      .rd_n_i  (rd_n_i),
      .addr_i  (addr_i),
      .din_i   (din_i),
      .sel_n_q (s_sel_n),
      .sel_q   (s_sel),
      .wr_n_q  (s_wr_n),
      .rd_n_q  (s_rd_n),
      .addr_q  (s_addr),
      .din_q   (s_din)
   );

   mode_e mode;
   logic  win;

   assign mode = decode_mode(s_sel_n, s_sel, s_wr_n, s_rd_n);
   assign win  = (mode == MODE_WRITE);

   logic [DEPTH_W-1:0] wr_idx;
   logic [DEPTH_W-1:0] rd_idx;
   logic [DATA_W-1:0]  hold_data;
   logic [DATA_W-1:0]  rdata;
   logic               commit;

   sram_emu_write_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(DEPTH_W)) i_wctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .win_i       (win),
      .addr_i      (s_addr),
      .data_i      (s_din),
      .hold_idx_o  (wr_idx),
      .hold_data_o (hold_data),
      .commit_o    (commit),
      .err_o       (proto_err_o)
   );

   if (DEPTH_W == ADDR_W) begin : g_full_index
      assign rd_idx = s_addr;
   end else begin : g_folded_index
      assign rd_idx = s_addr[DEPTH_W-1:0];
   end

   sram_emu_array #(.DATA_W(DATA_W), .DEPTH_W(DEPTH_W)) i_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (commit),
      .waddr_i (wr_idx),
      .wdata_i (hold_data),
      .raddr_i (rd_idx),
      .rdata_o (rdata)
   );

   // A byte about to be committed is forwarded to a read of the same index.
   logic fwd_hit;
   assign fwd_hit   = commit && (wr_idx == rd_idx);
   assign dout_en_o = (mode == MODE_READ);
   assign dout_o    = dout_en_o ? (fwd_hit ? hold_data : rdata) : '0;

   AST_DRIVE_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en_o |-> $past(!sel_n_i && sel_i && wr_n_i && !rd_n_i));        // R3
   AST_QUIET_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sel_n_i || !sel_i) |-> !dout_en_o);                            // R2
   AST_QUIET_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!wr_n_i) |-> !dout_en_o);                                      // R5
   AST_BUS_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en_o |-> (dout_o == '0));                                      // R3

endmodule

// File: tb/test_bytewide_sram_emu.sv
module test_bytewide_sram_emu;

   typedef struct packed {
      logic        sel_n;
      logic        sel;
      logic        wr_n;
      logic        rd_n;
      logic [19:0] addr;
      logic [7:0]  din;
      logic        exp_oe;
      logic [7:0]  exp_dout;
      logic [7:0]  req;
   } vec_t;

   localparam int NVEC = 20;
   localparam vec_t TBL [NVEC] = '{
      '{1'b0, 1'b1, 1'b0, 1'b1, 20'h00005, 8'hA5, 1'b0, 8'h00, 8'd6},
      '{1'b0, 1'b1, 1'b1, 1'b0, 20'h00005, 8'h00, 1'b1, 8'hA5, 8'd9},
      '{1'b0, 1'b1, 1'b0, 1'b0, 20'h00006, 8'h3C, 1'b0, 8'h00, 8'd5},
      '{1'b0, 1'b1, 1'b1, 1'b1, 20'h00006, 8'h00, 1'b0, 8'h00, 8'd4},
      '{1'b0, 1'b1, 1'b1, 1'b0, 20'h00006, 8'h00, 1'b1, 8'h3C, 8'd3},
      '{1'b1, 1'b1, 1'b0, 1'b0, 20'h00005, 8'hFF, 1'b0, 8'h00, 8'd2},
      '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00005, 8'h00, 1'b0, 8'h00, 8'd2},
      '{1'b0, 1'b1, 1'b1, 1'b0, 20'h00005, 8'h00, 1'b1, 8'hA5, 8'd11},
      '{1'b0, 1'b1, 1'b1, 1'b0, 20'h00405, 8'h00, 1'b1, 8'hA5, 8'd10},
      '{1'b0, 1'b1, 1'b0, 1'b1, 20'h00009, 8'h11, 1'b0, 8'h00, 8'd7},
      '{1'b0, 1'b1, 1'b0, 1'b1, 20'h00009, 8'h22, 1'b0, 8'h00, 8'd7},
      '{1'b0, 1'b1, 1'b0, 1'b1, 20'h00009, 8'h33, 1'b0, 8'h00, 8'd7},
      '{1'b0, 1'b1, 1'b1, 1'b0, 20'h00009, 8'h00, 1'b1, 8'h33, 8'd7},
      '{1'b0, 1'b1, 1'b0, 1'b1, 20'h0000A, 8'h44, 1'b0, 8'h00, 8'd6},
      '{1'b1, 1'b1, 1'b0, 1'b1, 20'h0000A, 8'h44, 1'b0, 8'h00, 8'd6},
      '{1'b0, 1'b1, 1'b1, 1'b0, 20'h0000A, 8'h00, 1'b1, 8'h44, 8'd6},
      '{1'b0, 1'b1, 1'b0, 1'b1, 20'h0000B, 8'h55, 1'b0, 8'h00, 8'd6},
      '{1'b0, 1'b0, 1'b0, 1'b1, 20'h0000B, 8'h55, 1'b0, 8'h00, 8'd6},
      '{1'b0, 1'b1, 1'b1, 1'b0, 20'h0000B, 8'h00, 1'b1, 8'h55, 8'd6},
      '{1'b0, 1'b1, 1'b1, 1'b0, 20'h0000A, 8'h00, 1'b1, 8'h44, 8'd3}
   };

   logic        clk;
   logic        rst_n;
   logic        sel_n, sel, wr_n, rd_n;
   logic [19:0] addr;
   logic [7:0]  din;
   logic [7:0]  dout;
   logic        dout_en;
   logic        perr;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   bytewide_sram_emu i_bytewide_sram_emu (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_n_i     (sel_n),
      .sel_i       (sel),
      .wr_n_i      (wr_n),
      .rd_n_i      (rd_n),
      .addr_i      (addr),
      .din_i       (din),
      .dout_o      (dout),
      .dout_en_o   (dout_en),
      .proto_err_o (perr)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   function automatic string req_tag(input int n);
      case (n)
         1:  return "R1";
         2:  return "R2";
         3:  return "R3";
         4:  return "R4";
         5:  return "R5";
         6:  return "R6";
         7:  return "R7";
         8:  return "R8";
         9:  return "R9";
         10: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int unsigned act, input int unsigned exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic sn, input logic s, input logic w, input logic r,
                        input logic [19:0] a, input logic [7:0] d);
      sel_n = sn; sel = s; wr_n = w; rd_n = r; addr = a; din = d;
      @(negedge clk);
   endtask

   task automatic idle();
      apply(1'b1, 1'b0, 1'b1, 1'b1, 20'h0, 8'h0);
   endtask

   initial begin
      rst_n = 1'b0;
      sel_n = 1'b1; sel = 1'b0; wr_n = 1'b1; rd_n = 1'b1; addr = '0; din = '0;
      repeat (3) @(negedge clk);
      // R1: state under reset
      check(dout_en == 1'b0, "R1", "dout_en in reset", dout_en, 0);
      check(perr == 1'b0,    "R1", "proto_err in reset", perr, 0);
      rst_n = 1'b1;
      idle();
      check(dout_en == 1'b0 && perr == 1'b0, "R1", "outputs after reset",
            {dout_en, perr}, 0);

      for (int i = 0; i < NVEC; i++) begin
         apply(TBL[i].sel_n, TBL[i].sel, TBL[i].wr_n, TBL[i].rd_n, TBL[i].addr, TBL[i].din);
         check(dout_en == TBL[i].exp_oe, req_tag(int'(TBL[i].req)), "dout_en",
               dout_en, TBL[i].exp_oe);
         if (TBL[i].exp_oe)
            check(dout == TBL[i].exp_dout, req_tag(int'(TBL[i].req)), "dout",
                  dout, TBL[i].exp_dout);
         else
            check(dout == 8'h00, "R3", "dout idle value", dout, 0);
         check(perr == 1'b0, "R8", "no spurious error", perr, 0);
      end

      // R8: address moves inside a window
      apply(1'b0, 1'b1, 1'b0, 1'b1, 20'h00020, 8'h66);
      apply(1'b0, 1'b1, 1'b1, 1'b0, 20'h00020, 8'h00);
      check(dout == 8'h66, "R9", "forwarded byte", dout, 8'h66);
      apply(1'b0, 1'b1, 1'b0, 1'b1, 20'h00020, 8'h77);
      apply(1'b0, 1'b1, 1'b0, 1'b1, 20'h00021, 8'h77);
      check(perr == 1'b0, "R8", "error not yet raised", perr, 0);
      idle();
      check(perr == 1'b1, "R8", "error raised", perr, 1);
      idle();
      check(perr == 1'b1, "R8", "error held", perr, 1);
      apply(1'b0, 1'b1, 1'b1, 1'b0, 20'h00020, 8'h00);
      check(dout_en == 1'b1 && dout == 8'h66, "R8", "suppressed write keeps old byte",
            dout, 8'h66);
      check(perr == 1'b1, "R8", "error held through read", perr, 1);
      apply(1'b0, 1'b1, 1'b0, 1'b1, 20'h00030, 8'h12);
      check(perr == 1'b1, "R8", "error until window opens", perr, 1);
      apply(1'b0, 1'b1, 1'b1, 1'b0, 20'h00030, 8'h00);
      check(perr == 1'b0, "R8", "error cleared by new window", perr, 0);
      check(dout == 8'h12, "R6", "write after error", dout, 8'h12);

      // R1: reset while an error is flagged and a read is requested
      apply(1'b0, 1'b1, 1'b0, 1'b1, 20'h00040, 8'h01);
      apply(1'b0, 1'b1, 1'b0, 1'b1, 20'h00041, 8'h01);
      idle();
      check(perr == 1'b1, "R8", "second error raised", perr, 1);
      rst_n = 1'b0;
      sel_n = 1'b0; sel = 1'b1; wr_n = 1'b1; rd_n = 1'b0; addr = 20'h00020;
      @(negedge clk);
      check(perr == 1'b0, "R1", "error cleared by reset", perr, 0);
      check(dout_en == 1'b0, "R1", "no drive in reset", dout_en, 0);
      rst_n = 1'b1;
      apply(1'b0, 1'b1, 1'b1, 1'b0, 20'h00020, 8'h00);
      check(dout_en == 1'b1 && dout == 8'h66, "R3", "storage kept over reset", dout, 8'h66);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule